// File: doc/BRIEF.md
# Wrapping Burst Read Sequencer

This block sits on the device side of a 16-bit memory read path. A host presents an address and pulls the address-valid strobe low while chip enable is low and write enable is high; the block latches that address and drives it to a synchronous array RAM, raising a data-valid flag for each word the host may take. The array itself lives outside the block; only the array address and the valid flag come out.

Two read modes exist. In asynchronous mode, which is what the block wakes up in, one word is presented and held for as long as the chip stays selected. In synchronous mode a clocked burst follows: the first word appears on the cycle after the address is taken, and every later word is spaced by a programmable latency of 3 to 7 cycles. The burst either counts upward without limit or wraps inside an aligned window of 4, 8, 16 or 32 words. One configuration word, written and read at a reserved address, holds the mode, the latency and the burst length.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the configuration word reads 16'h4000 (asynchronous mode, latency 4, continuous length) and `word_valid` is 0.
- R2: An address is latched on a clock edge where `ce_n`=0, `avd_n`=0 and `we_n`=1; on the next cycle `word_valid` is 1 and `arr_addr` equals that address, with no latency wait.
- R3: In asynchronous mode (mode bit 0), `word_valid` and `arr_addr` stay unchanged for as long as `ce_n` stays low and no new address is latched.
- R4: In synchronous mode (mode bit 1), `word_valid` is a one-cycle pulse; after the first word, each next word's pulse comes exactly L cycles after the previous one, where L is the stored latency.
- R5: With length code 0 or any code from 5 to 7, successive burst addresses increment by one and never wrap.
- R6: Length codes 1, 2, 3 and 4 select windows of 4, 8, 16 and 32 words; the burst address increments inside the aligned window holding the start address and wraps to the window base (start 2, code 1: 2, 3, 0, 1, 2).
- R7: A latency value of 0, 1 or 2 written to the configuration word is stored as 3; values 3 to 7 are stored unchanged.
- R8: The configuration word is written on an edge with `ce_n`=0, `we_n`=0, `avd_n`=0 and `addr` equal to `CFG_ADDR` (default 16'hFFF0); bit 15 is the mode, bits 14:12 the latency, bits 2:0 the length code, all other bits read 0. Writes to any other address leave it unchanged.
- R9: Latching `CFG_ADDR` makes `cfg_hit` 1 and `word_valid` 1 with `cfg_word` showing the stored settings, and no burst advance follows, in either mode.
- R10: Latching a new address during a burst abandons the old burst; the next cycle shows the new address as the first word and the latency count restarts from it.
- R11: An edge with `ce_n`=1 clears `word_valid` and `cfg_hit` on the next cycle, and they stay 0 until a new address is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| avd_n | input | 1 | Address-valid strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 16 | Host address |
| wdata | input | 16 | Host write data (configuration word) |
| arr_addr | output | 16 | Address presented to the array RAM |
| word_valid | output | 1 | Current word may be taken |
| cfg_hit | output | 1 | Current word is the configuration word, not array data |
| cfg_word | output | 16 | Stored configuration word |

## Verification
The assertions assume that the strobes are synchronous to `clk` and judged only at its rising edge, and that the configuration word is rewritten only while no burst is running, so that the mode and latency cannot change under a burst in flight. The bench drives every input on the falling edge, writes the configuration only after deselecting the chip, and draws random mode, length code, raw latency (including the values that must clamp) and start addresses near window edges, then replays each burst against a reference schedule built from the requirements. Directed cases cover the reset word, readback, ignored writes, re-latching mid-burst and deselect.

// File: rtl/brs_pkg.sv
package brs_pkg;
    localparam int          MAX_LEN_CODE = 4;
    localparam logic [2:0]  LAT_MIN      = 3'd3;
    localparam logic [2:0]  LAT_RESET    = 3'd4;

    typedef struct packed {
        logic       sync_mode;
        logic [2:0] lat;
        logic [2:0] len;
    } brs_cfg_t;

    function automatic logic [15:0] pack_cfg(brs_cfg_t c);
        return {c.sync_mode, c.lat, 9'b0, c.len};
    endfunction
endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
    import brs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wdata,
    output brs_cfg_t    cfg
);
    brs_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.sync_mode = wdata[15];
            cfg_d.lat       = (wdata[14:12] < LAT_MIN) ? LAT_MIN : wdata[14:12];
            cfg_d.len       = wdata[2:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{sync_mode: 1'b0, lat: LAT_RESET, len: 3'd0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    AST_LAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.lat >= LAT_MIN); // R7

    AST_WAKE_ASYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!cfg_q.sync_mode && cfg_q.lat == LAT_RESET)); // R1
endmodule

// File: rtl/brs_addr_step.sv
module brs_addr_step
    import brs_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [2:0]    len,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] mask;
    int            win_bits;

    always_comb begin
        win_bits = AW;
        for (int k = 1; k <= MAX_LEN_CODE; k++) begin
            if (int'(len) == k) win_bits = k + 1;
        end
        if (win_bits >= AW) mask = '1;
        else                mask = (AW'(1) << win_bits) - AW'(1);
        nxt = (cur & ~mask) | ((cur + AW'(1)) & mask);
    end
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
    import brs_pkg::*;
#(
    parameter int          AW       = 16,
    parameter logic [15:0] CFG_ADDR = 16'hFFF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          avd_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    output logic [AW-1:0] arr_addr,
    output logic          word_valid,
    output logic          cfg_hit,
    output logic [15:0]   cfg_word
);
    typedef struct packed {
        logic          busy;
        logic          valid;
        logic          hit;
        logic [AW-1:0] addr;
        logic [2:0]    cnt;
    } seq_t;

    seq_t     seq_d, seq_q;
    brs_cfg_t cfg;
    logic     take_addr;
    logic     cfg_wr;
    logic [AW-1:0] step_addr;

    assign take_addr = !ce_n && !avd_n && we_n;
    assign cfg_wr    = !ce_n && !avd_n && !we_n && (16'(addr) == CFG_ADDR);

    brs_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .wdata (wdata),
        .cfg   (cfg)
    );

    brs_addr_step #(.AW(AW)) u_step (
        .cur (seq_q.addr),
        .len (cfg.len),
        .nxt (step_addr)
    );

    always_comb begin
        seq_d = seq_q;
        if (ce_n) begin
            seq_d = '0;
        end else if (take_addr) begin
            seq_d.busy  = 1'b1;
            seq_d.valid = 1'b1;
            seq_d.hit   = (16'(addr) == CFG_ADDR);
            seq_d.addr  = addr;
            seq_d.cnt   = cfg.lat - 3'd1;
        end else if (seq_q.busy && !seq_q.hit && cfg.sync_mode) begin
            if (seq_q.cnt == 3'd0) begin
                seq_d.addr  = step_addr;
                seq_d.valid = 1'b1;
                seq_d.cnt   = cfg.lat - 3'd1;
            end else begin
                seq_d.valid = 1'b0;
                seq_d.cnt   = seq_q.cnt - 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign arr_addr   = seq_q.addr;
    assign word_valid = seq_q.valid;
    assign cfg_hit    = seq_q.hit;
    assign cfg_word   = pack_cfg(cfg);

    AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        take_addr |=> (word_valid && arr_addr == $past(addr))); // R2

    AST_ASYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !cfg.sync_mode && !ce_n && avd_n)
        |=> (word_valid && $stable(arr_addr))); // R3

    AST_SYNC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && cfg.sync_mode && !cfg_hit && !ce_n && avd_n)
        |=> !word_valid); // R4

    AST_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hit && !ce_n && avd_n) |=> (cfg_hit && word_valid && $stable(arr_addr))); // R9

    AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!word_valid && !cfg_hit)); // R11
endmodule

// File: tb/test_burst_read_seq.sv
module test_burst_read_seq;
    localparam logic [15:0] CFG = 16'hFFF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, avd_n = 1'b1, we_n = 1'b1;
    logic [15:0] addr = '0, wdata = '0;
    logic [15:0] arr_addr, cfg_word;
    logic        word_valid, cfg_hit;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_read_seq i_burst_read_seq (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .avd_n(avd_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .arr_addr(arr_addr),
        .word_valid(word_valid), .cfg_hit(cfg_hit), .cfg_word(cfg_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_next(input logic [15:0] a, input int len);
        int size;
        if (len >= 1 && len <= 4) begin
            size = 1 << (len + 1);
            return 16'((int'(a) / size) * size + ((int'(a) % size) + 1) % size);
        end
        return a + 16'd1;
    endfunction

    function automatic int eff_lat(input int raw);
        return (raw < 3) ? 3 : raw;
    endfunction

    task automatic write_cfg(input logic [15:0] a, input logic [15:0] d);
        ce_n = 1'b0; avd_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        ce_n = 1'b1; avd_n = 1'b1; we_n = 1'b1;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic latch(input logic [15:0] a);
        ce_n = 1'b0; avd_n = 1'b0; we_n = 1'b1; addr = a;
        @(posedge clk); @(negedge clk);
        avd_n = 1'b1;
    endtask

    task automatic deselect();
        ce_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R11 valid after deselect", word_valid, 1'b0);
        check("R11 hit after deselect", cfg_hit, 1'b0);
    endtask

    // Follow a burst already latched at a, for n sampled cycles.
    task automatic follow(input logic [15:0] a, input bit sm, input int len, input int lat, input int n);
        logic [15:0] exp_a = a;
        for (int t = 0; t < n; t++) begin
            bit exp_v = sm ? ((t % lat) == 0) : 1'b1;
            if (t == 0) check("R2 first word valid", word_valid, 1'b1);
            else if (sm) check("R4 pulse spacing", word_valid, exp_v);
            else check("R3 async hold valid", word_valid, 1'b1);
            if (exp_v) begin
                if (sm && (len == 0 || len > 4)) check("R5 linear address", arr_addr, exp_a);
                else if (sm) check("R6 wrapped address", arr_addr, exp_a);
                else check("R3 async address", arr_addr, exp_a);
                if (sm) exp_a = ref_next(exp_a, len);
            end
            @(posedge clk); @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset cfg word", cfg_word, 16'h4000);
        check("R1 reset valid", word_valid, 1'b0);

        // R3 directed async read with hold
        latch(16'h0123);
        follow(16'h0123, 1'b0, 0, 4, 6);
        deselect();

        // R6 directed: 4-word wrap from 2, latency 3
        write_cfg(CFG, 16'h8001 | (16'd3 << 12));
        check("R8 cfg write", cfg_word, 16'hB001);
        latch(16'h0002);
        follow(16'h0002, 1'b1, 1, 3, 16);
        deselect();

        // R7 clamp of low latency, R5 code 6 is linear
        write_cfg(CFG, 16'h8006 | (16'd1 << 12));
        check("R7 clamped latency", cfg_word, 16'hB006);
        latch(16'h00FE);
        follow(16'h00FE, 1'b1, 6, 3, 12);
        deselect();

        // R8 write to another address ignored
        write_cfg(16'h1234, 16'h0003);
        check("R8 ignored write", cfg_word, 16'hB006);

        // R9 readback during burst, in sync mode
        latch(16'h0040);
        follow(16'h0040, 1'b1, 6, 3, 4);
        latch(CFG);
        for (int t = 0; t < 5; t++) begin
            check("R9 hit flag", cfg_hit, 1'b1);
            check("R9 valid held", word_valid, 1'b1);
            check("R9 readback word", cfg_word, 16'hB006);
            @(posedge clk); @(negedge clk);
        end
        deselect();

        // R10 re-latch mid-burst restarts timing and address
        write_cfg(CFG, 16'h8003 | (16'd5 << 12));
        latch(16'h0010);
        follow(16'h0010, 1'b1, 3, 5, 7);
        latch(16'h001E);
        check("R10 new first word", arr_addr, 16'h001E);
        follow(16'h001E, 1'b1, 3, 5, 12);
        deselect();

        // Random bursts
        for (int i = 0; i < 40; i++) begin
            bit          sm  = 1'($urandom_range(0, 3) != 0);
            int          len = int'($urandom_range(0, 7));
            int          raw = int'($urandom_range(0, 7));
            logic [15:0] a   = 16'($urandom_range(0, 16'hFF00));
            int          n   = int'($urandom_range(8, 60));
            if (($urandom & 1) != 0) a = 16'({a[15:5], 5'h1F} - 16'($urandom_range(0, 2)));
            write_cfg(CFG, {sm, 3'(raw), 9'b0, 3'(len)});
            check("R8 random cfg readback", cfg_word,
                  {sm, 3'(eff_lat(raw)), 9'b0, 3'(len)});
            latch(a);
            follow(a, sm, len, eff_lat(raw), n);
            deselect();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule